// File: doc/BRIEF.md
# Protected Data EEPROM Controller

This block sits on a CPU's register bus and fronts a small byte-wide nonvolatile data store. Software picks a byte through an address register and moves bytes through a data register. A read request copies the addressed byte into the data register, where software can collect it on the following cycle. Programming a byte is guarded twice. First, a write-enable bit must already be set. Second, a two-key handshake must be played on a dedicated key register with exact spacing in time. Only after both does the controller start a timed programming cycle and hold a busy indication for its whole length.

When programming ends, the go bit drops and a sticky done flag rises. Only software can clear that flag. The flag can drive a level interrupt, gated by a local enable input. The storage is an internal register file that is filled with FFh at reset. The write duration and the spacing of the handshake steps are set by parameters.

Register select (`bus_sel`): 0 = address, 1 = data, 2 = control, 3 = key. Control bits: bit0 = read request (self-clearing, reads 0), bit1 = write enable, bit2 = go (write in progress), bit3 = done flag. Bits 7..4 read 0.

Top module: `nvb_eeprom_ctrl`

## Requirements
- R1: When control (select 2) is written with bit0 = 1 while not busy, the byte at the current address is loaded into the data register, and it can be read back on the cycle right after that bus write.
- R2: The data register holds its value until another read request or a software write to the data register (select 1); writes to other registers leave it unchanged.
- R3: A write starts only when 55h is written to the key register (select 3), then AAh is written to it STEP_GAP cycles later, then control is written with bit2 = 1 another STEP_GAP cycles later. Wrong key values or a wrong key order start nothing.
- R4: If any step of the handshake comes earlier or later than exactly STEP_GAP cycles after the previous one, the unlock is cancelled and no write begins.
- R5: A write can start only if the write-enable bit (bit1) was already set before the cycle of the control write that sets bit2. Setting both in that same write starts nothing.
- R6: Hardware never clears write enable, and clearing it while a write is running does not abort that write.
- R7: A write keeps busy and control bit2 high for exactly WRITE_CYCLES cycles. Then bit2 clears, bit3 (done) sets, and the data-register byte is stored at the address-register location.
- R8: The done flag stays set until software writes control with bit3 = 0. Writing bit3 = 1 has no effect on it.
- R9: The key register always reads as 00h.
- R10: While busy, read requests and writes to the address and data registers are ignored.
- R11: After reset every array byte reads FFh, the address, data and control registers read 00h, and busy and irq are low.
- R12: irq is high exactly when the done flag is set and irq_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | A programming cycle is in progress |
| irq_en | input | 1 | Local interrupt enable |
| irq | output | 1 | Level interrupt: done flag and irq_en |

## Verification
The hardest state to reach from the ports is an unlock that fails only because of timing. The key values and their order are correct, and only the spacing is off by a single cycle, either early or late. The bench drives every bus write from a task that spends exactly one clock on it, and it pads with a counted number of idle cycles. Because of this it can place the AAh key and the go write one cycle early or one cycle late. It then checks that busy stays low and that the target byte is unchanged. A second hard case is a write that is already running while software clears write enable and tries to change address, data or read. The bench issues these writes between the start edge and the end edge of the timed cycle.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_KEY1 = 2'd1,
    UL_KEY2 = 2'd2
  } ul_state_e;

  localparam int CB_RD   = 0;
  localparam int CB_WEN  = 1;
  localparam int CB_GO   = 2;
  localparam int CB_DONE = 3;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  // control register image as seen on the bus
  function automatic logic [7:0] pack_ctrl(input logic wen, input logic go, input logic done);
    logic [7:0] v;
    v = 8'h00;
    v[CB_WEN]  = wen;
    v[CB_GO]   = go;
    v[CB_DONE] = done;
    return v;
  endfunction

  // true when the step counter sits on the one permitted cycle
  function automatic logic step_due(input int unsigned cnt, input int unsigned gap);
    return cnt == gap;
  endfunction

endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
  import nvb_pkg::*;
#(
  parameter int STEP_GAP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       ctrl_wr,
  input  logic       ctrl_go,
  output logic       start_ok
);

  localparam int CW = $clog2(STEP_GAP + 1);

  ul_state_e     state;
  logic [CW-1:0] cnt;
  logic          on_time;

  assign on_time  = step_due(int'(cnt), STEP_GAP);
  assign start_ok = (state == UL_KEY2) && on_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= UL_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        UL_IDLE: begin
          if (key_wr && key_val == KEY_FIRST) begin
            state <= UL_KEY1;
            cnt   <= CW'(1);
          end
        end
        UL_KEY1: begin
          if (key_wr) begin
            if (on_time && key_val == KEY_SECOND) begin
              state <= UL_KEY2;
              cnt   <= CW'(1);
            end else begin
              state <= UL_IDLE;
              cnt   <= '0;
            end
          end else if (on_time) begin
            state <= UL_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        UL_KEY2: begin
          // the arm is consumed on its due cycle, or cancelled by any stray step
          if (key_wr || (ctrl_wr && ctrl_go) || on_time) begin
            state <= UL_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          state <= UL_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R3: second stage is only entered from the first stage on the second key
  a_r3_key_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == UL_KEY2 && $past(state) != UL_KEY2) |->
      ($past(state) == UL_KEY1 && $past(key_val) == KEY_SECOND && $past(key_wr)));

  // R4: an armed stage never outlives its window
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state != UL_IDLE) |-> (cnt >= CW'(1) && int'(cnt) <= STEP_GAP));

endmodule

// File: rtl/nvb_wtimer.sv
module nvb_wtimer #(
  parameter int WRITE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic finish
);

  localparam int TW = $clog2(WRITE_CYCLES + 1);

  logic [TW-1:0] remain;

  assign busy   = (remain != '0);
  assign finish = (remain == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start && !busy) begin
      remain <= TW'(WRITE_CYCLES);
    end else if (busy) begin
      remain <= remain - TW'(1);
    end
  end

  // R7: a start opens the busy window on the next cycle
  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R7: the last cycle of the window closes it
  a_r7_finish_ends: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);

  // R7: no second start while a write runs
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  assign rdata = cells[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/nvb_eeprom_ctrl.sv
module nvb_eeprom_ctrl
  import nvb_pkg::*;
#(
  parameter int AW           = 8,
  parameter int WRITE_CYCLES = 8,
  parameter int STEP_GAP     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       busy,
  input  logic       irq_en,
  output logic       irq
);

  reg_sel_e      sel;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wen_q;
  logic          go_q;
  logic          done_q;

  // named internal events
  logic       ctrl_wr;
  logic       key_wr;
  logic       rd_req;
  logic       go_req;
  logic       go_accept;
  logic       start_ok;
  logic       busy_w;
  logic       finish;
  logic [7:0] arr_rdata;

  assign sel       = reg_sel_e'(bus_sel);
  assign ctrl_wr   = bus_we && (sel == SEL_CTRL);
  assign key_wr    = bus_we && (sel == SEL_KEY);
  assign rd_req    = ctrl_wr && bus_wdata[CB_RD] && !busy_w;
  assign go_req    = ctrl_wr && bus_wdata[CB_GO];
  assign go_accept = go_req && wen_q && start_ok && !busy_w;

  nvb_unlock #(.STEP_GAP(STEP_GAP)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_val  (bus_wdata),
    .ctrl_wr  (ctrl_wr),
    .ctrl_go  (bus_wdata[CB_GO]),
    .start_ok (start_ok)
  );

  nvb_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (go_accept),
    .busy   (busy_w),
    .finish (finish)
  );

  nvb_store #(.AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (finish),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wen_q  <= 1'b0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (bus_we && sel == SEL_ADDR && !busy_w) addr_q <= bus_wdata[AW-1:0];

      if (rd_req)                                    data_q <= arr_rdata;
      else if (bus_we && sel == SEL_DATA && !busy_w) data_q <= bus_wdata;

      if (ctrl_wr) wen_q <= bus_wdata[CB_WEN];

      if (go_accept)   go_q <= 1'b1;
      else if (finish) go_q <= 1'b0;

      if (finish)                             done_q <= 1'b1;
      else if (ctrl_wr && !bus_wdata[CB_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ADDR: bus_rdata = 8'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = pack_ctrl(wen_q, go_q, done_q);
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign busy = busy_w;
  assign irq  = done_q && irq_en;

  // R1: a read request lands the array byte in the data register next cycle
  a_r1_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (data_q == $past(arr_rdata)));

  // R2: without a read or a data write the data register holds
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !(bus_we && sel == SEL_DATA)) |=> $stable(data_q));

  // R3: go rises only out of a completed handshake
  a_r3_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(start_ok));

  // R5: go rises only with write enable already set
  a_r5_start_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(wen_q));

  // R6: write enable changes only by a control write
  a_r6_wen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(wen_q));

  // R7: the go bit and the timer agree, and its fall marks completion
  a_r7_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_q == busy_w);
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_q) |-> done_q);

  // R8: done stays unless software clears it
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(ctrl_wr && !bus_wdata[CB_DONE])) |=> done_q);

  // R10: address is frozen while a write runs
  a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(addr_q));

endmodule

// File: tb/nvb_eeprom_ctrl_test.sv
module nvb_eeprom_ctrl_test;

  localparam int W   = 8;
  localparam int GAP = 2;
  localparam logic [1:0] S_ADDR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_KEY = 2'd3;

  // stimulus vectors: {address, data}; expected readback equals data
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h005A, 16'hFFA5, 16'h0100, 16'h80FF, 16'h7F3C, 16'h10C3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       busy;
  logic       irq_en = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  nvb_eeprom_ctrl #(.AW(8), .WRITE_CYCLES(W), .STEP_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // one bus write occupying exactly one clock; call at a negedge
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic handshake(input logic [7:0] k1, input logic [7:0] k2,
                           input int g1, input int g2, input logic [7:0] c);
    wr(S_KEY, k1);
    idle(g1 - 1);
    wr(S_KEY, k2);
    idle(g2 - 1);
    wr(S_CTRL, c);
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
    wr(S_ADDR, a);
    wr(S_CTRL, 8'h01);
    peek(S_DATA, v);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    logic [7:0] a;
    logic [7:0] d;
    idle(2);
    rst_n = 1'b1;
    idle(1);

    // R11: reset state
    peek(S_ADDR, v); chk("R11 addr", v, 8'h00);
    peek(S_DATA, v); chk("R11 data", v, 8'h00);
    peek(S_CTRL, v); chk("R11 ctrl", v, 8'h00);
    chk("R11 busy", {7'd0, busy}, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
    rd_byte(8'h77, v); chk("R11 array FF", v, 8'hFF);

    // R9: key register reads zero
    wr(S_KEY, 8'h55);
    peek(S_KEY, v); chk("R9 key reads 0", v, 8'h00);
    idle(4);

    // vector table: full write then readback (R7, R1)
    for (int i = 0; i < NV; i++) begin
      a = VEC[i][15:8];
      d = VEC[i][7:0];
      wr(S_ADDR, a);
      wr(S_DATA, d);
      wr(S_CTRL, 8'h02);
      handshake(8'h55, 8'hAA, GAP, GAP, 8'h06);
      chk("R7 busy starts", {7'd0, busy}, 8'h01);
      idle(W - 1);
      chk("R7 busy last cycle", {7'd0, busy}, 8'h01);
      peek(S_CTRL, v); chk("R7 go high", v, 8'h06);
      idle(1);
      chk("R7 busy ends", {7'd0, busy}, 8'h00);
      peek(S_CTRL, v); chk("R7 go clear done set", v, 8'h0A);
      rd_byte(a, v); chk("R1 R7 readback", v, d);
    end

    // R2: data holds across address writes and key writes
    wr(S_ADDR, 8'h33);
    wr(S_KEY, 8'h12);
    peek(S_DATA, v); chk("R2 data held", v, 8'hC3);
    wr(S_DATA, 8'h9E);
    peek(S_DATA, v); chk("R2 software write", v, 8'h9E);

    // R5: wen set in the same write as go is too late
    wr(S_ADDR, 8'h20); wr(S_DATA, 8'h11); wr(S_CTRL, 8'h00);
    handshake(8'h55, 8'hAA, GAP, GAP, 8'h06);
    chk("R5 no start", {7'd0, busy}, 8'h00);
    idle(W + 1);
    rd_byte(8'h20, v); chk("R5 byte unchanged", v, 8'hFF);

    // R3: wrong order and wrong value
    wr(S_DATA, 8'h11); wr(S_CTRL, 8'h02);
    handshake(8'hAA, 8'h55, GAP, GAP, 8'h06);
    chk("R3 wrong order", {7'd0, busy}, 8'h00);
    idle(3);
    handshake(8'h55, 8'hA5, GAP, GAP, 8'h06);
    chk("R3 wrong value", {7'd0, busy}, 8'h00);
    idle(3);

    // R4: early and late steps
    handshake(8'h55, 8'hAA, GAP - 1, GAP, 8'h06);
    chk("R4 early key", {7'd0, busy}, 8'h00);
    idle(3);
    handshake(8'h55, 8'hAA, GAP + 1, GAP, 8'h06);
    chk("R4 late key", {7'd0, busy}, 8'h00);
    idle(3);
    handshake(8'h55, 8'hAA, GAP, GAP - 1, 8'h06);
    chk("R4 early go", {7'd0, busy}, 8'h00);
    idle(3);
    handshake(8'h55, 8'hAA, GAP, GAP + 1, 8'h06);
    chk("R4 late go", {7'd0, busy}, 8'h00);
    idle(W + 1);
    rd_byte(8'h20, v); chk("R3 R4 byte unchanged", v, 8'hFF);

    // R6 and R10: clear wen and disturb registers during a write
    wr(S_ADDR, 8'h20); wr(S_DATA, 8'h6B); wr(S_CTRL, 8'h02);
    handshake(8'h55, 8'hAA, GAP, GAP, 8'h06);
    wr(S_CTRL, 8'h00);
    wr(S_ADDR, 8'h21);
    wr(S_DATA, 8'h00);
    wr(S_CTRL, 8'h01);
    chk("R6 still busy", {7'd0, busy}, 8'h01);
    idle(W - 4);
    chk("R6 busy ended", {7'd0, busy}, 8'h00);
    peek(S_ADDR, v); chk("R10 addr ignored", v, 8'h20);
    peek(S_DATA, v); chk("R10 data ignored", v, 8'h6B);
    peek(S_CTRL, v); chk("R6 done wen cleared by sw", v, 8'h08);

    // R12 and R8: interrupt gating and sticky done
    chk("R12 masked", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;
    #1 chk("R12 raised", {7'd0, irq}, 8'h01);
    idle(1);
    wr(S_CTRL, 8'h0A);
    peek(S_CTRL, v); chk("R8 write one keeps done", v, 8'h0A);
    chk("R6 wen kept by hw", v & 8'h02, 8'h02);
    idle(5);
    peek(S_CTRL, v); chk("R8 done sticky", v, 8'h0A);
    wr(S_CTRL, 8'h02);
    peek(S_CTRL, v); chk("R8 cleared", v, 8'h02);
    chk("R12 dropped", {7'd0, irq}, 8'h00);

    rd_byte(8'h20, v); chk("R6 write completed", v, 8'h6B);
    rd_byte(8'h21, v); chk("R10 neighbour untouched", v, 8'hFF);

    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule